// File: doc/BRIEF.md
# Harmonic Power Sign-Gradient Tracker

This block closes a slow calibration loop around a converter's correction datapath. It receives a stream of high-pass-filtered samples, whose remaining content is taken as harmonic energy. It measures how much energy falls inside each window marked by a periodic trigger. Every fourth window it forms a power estimate and nudges a signed step-error word one fixed increment uphill or downhill. The direction comes only from the sign of the change in power since the previous estimate. Once the power has no clear slope left, the word dithers by one code around the point of least harmonic energy.

Window power is the sum of sample magnitudes, which avoids a multiplier and a square root. The estimate is the mean of four consecutive window powers, formed by a right shift. The step word is a 12-bit two's complement number with 5 fractional bits, so one code equals 1/32 of a converter LSB. A sequencer with five named states handles the adaptation: ST_PRIME waits for the first estimate after reset, ST_LOAD stores that estimate without moving the step word, ST_WAIT waits for each later estimate, ST_DECIDE compares it with the stored one, and ST_APPLY moves the step word and stores the new estimate. The transitions are ST_PRIME→ST_LOAD (estimate ready), ST_LOAD→ST_WAIT, ST_WAIT→ST_DECIDE (estimate ready), ST_DECIDE→ST_APPLY and ST_APPLY→ST_WAIT.

Top module: `harmonic_sign_tracker`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `pwr_est` and `step_word` are zero and `upd_stb` is low.
- R2: A window's power is the sum of |`smp_data`| over the cycles with `smp_valid` high, from the cycle after one `trig` up to and including the cycle before the next. A valid sample in a `trig` cycle belongs to the new window. Samples with `smp_valid` low add nothing.
- R3: A window of up to MAX_WIN_LEN samples, each of magnitude 2^(SAMPLE_W-1), is summed without overflow. With the defaults, four such windows give `pwr_est` = 8388608.
- R4: The power estimate is the sum of four consecutive window powers shifted right by 2 and truncated.
- R5: `upd_stb` pulses for exactly one cycle per four triggers. `pwr_est` and `step_word` change only in a cycle where `upd_stb` is high. The pulse comes on the 3rd or 4th rising edge after the edge that samples the fourth `trig`.
- R6: The first update after reset loads `pwr_est` and leaves `step_word` unchanged.
- R7: If the new estimate is greater than the previous one, `step_word` rises by one code (1/32 LSB).
- R8: If the new estimate is smaller than the previous one, `step_word` falls by one code.
- R9: If the new estimate equals the previous one, `step_word` holds.
- R10: `step_word` saturates at +2047 and −2048 and never wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Qualifies `smp_data` |
| smp_data | input | SAMPLE_W | Filtered sample, two's complement |
| trig | input | 1 | Window boundary pulse |
| pwr_est | output | SAMPLE_W+clog2(MAX_WIN_LEN) | Four-window averaged power estimate |
| step_word | output | STEP_W | Step-error word, two's complement, 5 fraction bits |
| upd_stb | output | 1 | One-cycle pulse when the estimate and step word are updated |

## Verification
The saturation limits are the hardest condition to reach from the ports. The step word moves by only one code for every four windows, so reaching +2047 from zero takes more than two thousand estimates that rise strictly. Reaching −2048 from the top takes more than four thousand that fall strictly. The stimulus drives ramps of averages, one up and one down, with each window's power split over several samples of alternating sign. It then drives one extra estimate past each limit. The equal-power hold is reached by choosing window powers whose sums differ but truncate to the same estimate.

// File: rtl/hst_pkg.sv
`timescale 1ns/1ps
package hst_pkg;

    typedef enum logic [2:0] {
        ST_PRIME,
        ST_LOAD,
        ST_WAIT,
        ST_DECIDE,
        ST_APPLY
    } trk_state_t;

    typedef enum logic [1:0] {
        DIR_HOLD,
        DIR_UP,
        DIR_DOWN
    } step_dir_t;

endpackage

// File: rtl/hst_window_accum.sv
`timescale 1ns/1ps
module hst_window_accum #(
    parameter int SAMPLE_W    = 12,
    parameter int MAX_WIN_LEN = 4096,
    localparam int ACC_W      = SAMPLE_W + $clog2(MAX_WIN_LEN)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] smp_data,
    input  logic                       win_close,
    output logic [ACC_W-1:0]           win_pwr,
    output logic                       win_pwr_vld
);

    logic [SAMPLE_W-1:0] mag;
    logic [ACC_W-1:0]    mag_ext;
    logic [ACC_W-1:0]    acc_q;

    // magnitude; the most negative code maps onto 2^(SAMPLE_W-1) unsigned
    always_comb begin
        if (smp_data[SAMPLE_W-1]) begin
            mag = $unsigned(-smp_data);
        end else begin
            mag = $unsigned(smp_data);
        end
        mag_ext = ACC_W'(mag);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q       <= '0;
            win_pwr     <= '0;
            win_pwr_vld <= 1'b0;
        end else begin
            win_pwr_vld <= win_close;
            if (win_close) begin
                win_pwr <= acc_q;
                acc_q   <= smp_valid ? mag_ext : '0;
            end else if (smp_valid) begin
                acc_q <= acc_q + mag_ext;
            end
        end
    end

endmodule

// File: rtl/hst_quad_avg.sv
`timescale 1ns/1ps
module hst_quad_avg #(
    parameter int PWR_W    = 24,
    parameter int AVG_LOG2 = 2,
    localparam int SUM_W   = PWR_W + AVG_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PWR_W-1:0] in_pwr,
    input  logic             in_vld,
    output logic [PWR_W-1:0] avg_pwr,
    output logic             avg_vld
);

    logic [AVG_LOG2-1:0] cnt_q;
    logic [SUM_W-1:0]    sum_q;
    logic [SUM_W-1:0]    sum_next;
    logic                last_win;

    always_comb begin
        sum_next = sum_q + SUM_W'(in_pwr);
        last_win = (cnt_q == '1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            sum_q   <= '0;
            avg_pwr <= '0;
            avg_vld <= 1'b0;
        end else begin
            avg_vld <= 1'b0;
            if (in_vld) begin
                cnt_q <= cnt_q + 1'b1;
                if (last_win) begin
                    sum_q   <= '0;
                    avg_pwr <= PWR_W'(sum_next >> AVG_LOG2);
                    avg_vld <= 1'b1;
                end else begin
                    sum_q <= sum_next;
                end
            end
        end
    end

endmodule

// File: rtl/hst_sign_stepper.sv
`timescale 1ns/1ps
module hst_sign_stepper
    import hst_pkg::*;
#(
    parameter int PWR_W    = 24,
    parameter int STEP_W   = 12,
    parameter int STEP_INC = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PWR_W-1:0]         avg_pwr,
    input  logic                     avg_vld,
    output logic [PWR_W-1:0]         pwr_est,
    output logic signed [STEP_W-1:0] step_word,
    output logic                     upd_stb
);

    localparam logic signed [STEP_W:0] INC_X = (STEP_W+1)'(STEP_INC);
    localparam logic signed [STEP_W:0] MAX_X = (STEP_W+1)'((1 << (STEP_W-1)) - 1);
    localparam logic signed [STEP_W:0] MIN_X = (STEP_W+1)'(-(1 << (STEP_W-1)));

    trk_state_t state_q, state_d;
    step_dir_t  dir_q;

    logic [PWR_W-1:0]         pwr_cur_q;
    logic [PWR_W-1:0]         pwr_prev_q;
    logic signed [STEP_W-1:0] step_q;
    logic signed [PWR_W:0]    pwr_diff;
    logic signed [STEP_W:0]   step_ext;
    logic signed [STEP_W:0]   step_up;
    logic signed [STEP_W:0]   step_dn;
    logic signed [STEP_W:0]   step_new;

    // comparator path and saturating step arithmetic
    always_comb begin
        pwr_diff = $signed({1'b0, pwr_cur_q}) - $signed({1'b0, pwr_prev_q});
        step_ext = {step_q[STEP_W-1], step_q};
        step_up  = step_ext + INC_X;
        step_dn  = step_ext - INC_X;
        step_new = step_ext;
        if (dir_q == DIR_UP) begin
            step_new = (step_up > MAX_X) ? MAX_X : step_up;
        end else if (dir_q == DIR_DOWN) begin
            step_new = (step_dn < MIN_X) ? MIN_X : step_dn;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PRIME;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME:  state_d = avg_vld ? ST_LOAD : ST_PRIME;
            ST_LOAD:   state_d = ST_WAIT;
            ST_WAIT:   state_d = avg_vld ? ST_DECIDE : ST_WAIT;
            ST_DECIDE: state_d = ST_APPLY;
            ST_APPLY:  state_d = ST_WAIT;
            default:   state_d = ST_PRIME;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_cur_q  <= '0;
            pwr_prev_q <= '0;
            dir_q      <= DIR_HOLD;
            step_q     <= '0;
            pwr_est    <= '0;
            upd_stb    <= 1'b0;
        end else begin
            upd_stb <= 1'b0;
            unique case (state_q)
                ST_PRIME: begin
                    if (avg_vld) begin
                        pwr_cur_q <= avg_pwr;
                    end
                end
                ST_LOAD: begin
                    pwr_prev_q <= pwr_cur_q;
                    pwr_est    <= pwr_cur_q;
                    upd_stb    <= 1'b1;
                end
                ST_WAIT: begin
                    if (avg_vld) begin
                        pwr_cur_q <= avg_pwr;
                    end
                end
                ST_DECIDE: begin
                    if (pwr_diff[PWR_W]) begin
                        dir_q <= DIR_DOWN;
                    end else if (pwr_diff != '0) begin
                        dir_q <= DIR_UP;
                    end else begin
                        dir_q <= DIR_HOLD;
                    end
                end
                ST_APPLY: begin
                    pwr_prev_q <= pwr_cur_q;
                    pwr_est    <= pwr_cur_q;
                    step_q     <= step_new[STEP_W-1:0];
                    upd_stb    <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    assign step_word = step_q;

endmodule

// File: rtl/harmonic_sign_tracker.sv
`timescale 1ns/1ps
module harmonic_sign_tracker #(
    parameter int SAMPLE_W    = 12,
    parameter int MAX_WIN_LEN = 4096,
    parameter int AVG_LOG2    = 2,
    parameter int STEP_W      = 12,
    parameter int STEP_INC    = 1,
    localparam int PWR_W      = SAMPLE_W + $clog2(MAX_WIN_LEN)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] smp_data,
    input  logic                       trig,
    output logic [PWR_W-1:0]           pwr_est,
    output logic signed [STEP_W-1:0]   step_word,
    output logic                       upd_stb
);

    logic [PWR_W-1:0] win_pwr;
    logic             win_pwr_vld;
    logic [PWR_W-1:0] avg_pwr;
    logic             avg_vld;

    hst_window_accum #(
        .SAMPLE_W    (SAMPLE_W),
        .MAX_WIN_LEN (MAX_WIN_LEN)
    ) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid   (smp_valid),
        .smp_data    (smp_data),
        .win_close   (trig),
        .win_pwr     (win_pwr),
        .win_pwr_vld (win_pwr_vld)
    );

    hst_quad_avg #(
        .PWR_W    (PWR_W),
        .AVG_LOG2 (AVG_LOG2)
    ) u_avg (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_pwr  (win_pwr),
        .in_vld  (win_pwr_vld),
        .avg_pwr (avg_pwr),
        .avg_vld (avg_vld)
    );

    hst_sign_stepper #(
        .PWR_W    (PWR_W),
        .STEP_W   (STEP_W),
        .STEP_INC (STEP_INC)
    ) u_stepper (
        .clk       (clk),
        .rst_n     (rst_n),
        .avg_pwr   (avg_pwr),
        .avg_vld   (avg_vld),
        .pwr_est   (pwr_est),
        .step_word (step_word),
        .upd_stb   (upd_stb)
    );

endmodule

// File: rtl/hst_checker.sv
`timescale 1ns/1ps
module hst_checker #(
    parameter int PWR_W    = 24,
    parameter int STEP_W   = 12,
    parameter int STEP_INC = 1,
    parameter int AVG_N    = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     trig,
    input logic [PWR_W-1:0]         pwr_est,
    input logic signed [STEP_W-1:0] step_word,
    input logic                     upd_stb
);

    localparam logic signed [STEP_W:0]   INC_X  = (STEP_W+1)'(STEP_INC);
    localparam logic signed [STEP_W:0]   NINC_X = (STEP_W+1)'(-STEP_INC);
    localparam logic signed [STEP_W-1:0] S_MAX  = STEP_W'((1 << (STEP_W-1)) - 1);
    localparam logic signed [STEP_W-1:0] S_MIN  = STEP_W'(-(1 << (STEP_W-1)));

    logic signed [STEP_W-1:0] step_prev;
    logic signed [STEP_W:0]   step_delta;
    int unsigned              trig_total;
    int unsigned              stb_total;
    logic                     seen_stb;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_prev  <= '0;
            trig_total <= 0;
            stb_total  <= 0;
            seen_stb   <= 1'b0;
        end else begin
            step_prev <= step_word;
            if (trig) trig_total <= trig_total + 1;
            if (upd_stb) begin
                stb_total <= stb_total + 1;
                seen_stb  <= 1'b1;
            end
        end
    end

    always_comb begin
        step_delta = {step_word[STEP_W-1], step_word} - {step_prev[STEP_W-1], step_prev};
    end

    // R7 / R8: the word moves only on a strobe and only by one increment
    p_step_unit_move_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_word != step_prev) |-> (upd_stb && (step_delta == INC_X || step_delta == NINC_X)));

    p_est_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_stb |-> $stable(pwr_est));

    p_strobe_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |=> !upd_stb);

    p_quarter_rate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |-> (trig_total >= AVG_N * (stb_total + 1)));

    p_prime_keeps_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && !seen_stb) |-> (step_word == '0));

    p_no_wrap_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (step_prev == S_MAX) |-> (step_word != S_MIN));

    p_no_wrap_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (step_prev == S_MIN) |-> (step_word != S_MAX));

endmodule

bind harmonic_sign_tracker hst_checker #(
    .PWR_W    (PWR_W),
    .STEP_W   (STEP_W),
    .STEP_INC (STEP_INC),
    .AVG_N    (1 << AVG_LOG2)
) u_hst_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .pwr_est   (pwr_est),
    .step_word (step_word),
    .upd_stb   (upd_stb)
);

// File: tb/harmonic_sign_tracker_bench.sv
`timescale 1ns/1ps
module harmonic_sign_tracker_bench;

    localparam int SAMPLE_W    = 12;
    localparam int MAX_WIN_LEN = 4096;
    localparam int STEP_W      = 12;
    localparam int PWR_W       = SAMPLE_W + $clog2(MAX_WIN_LEN);
    localparam int N_VEC       = 10;

    // window0..3 powers, expected estimate, expected step word
    localparam int VEC [0:N_VEC-1][0:5] = '{
        '{ 10,  20,  30,  40, 25,  0},
        '{ 30,  30,  30,  30, 30,  1},
        '{ 40,  40,  40,  43, 40,  2},
        '{ 10,  10,  10,  10, 10,  1},
        '{ 10,  10,  10,  11, 10,  1},
        '{  5,   5,   5,   5,  5,  0},
        '{  3,   3,   3,   3,  3, -1},
        '{  2,   2,   2,   2,  2, -2},
        '{100,   0,   0,   0, 25, -1},
        '{  0,   0,   0,   0,  0, -2}
    };

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic                       smp_valid = 1'b0;
    logic signed [SAMPLE_W-1:0] smp_data = '0;
    logic                       trig = 1'b0;
    wire  [PWR_W-1:0]           pwr_est;
    wire  signed [STEP_W-1:0]   step_word;
    wire                        upd_stb;

    int checks = 0;
    int fails = 0;
    int stb_seen = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    harmonic_sign_tracker u_harmonic_sign_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .trig      (trig),
        .pwr_est   (pwr_est),
        .step_word (step_word),
        .upd_stb   (upd_stb)
    );

    always @(negedge clk) begin
        if (rst_n && upd_stb) stb_seen++;
    end

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input bit v, input int d, input bit t);
        @(negedge clk);
        smp_valid = v;
        smp_data  = SAMPLE_W'(d);
        trig      = t;
    endtask

    task automatic settle();
        repeat (8) drive(1'b0, 0, 1'b0);
    endtask

    task automatic send_window(input int p);
        int rem;
        bit neg;
        rem = p;
        neg = 1'b0;
        while (rem > 0) begin
            int m;
            m = (rem > 2000) ? 2000 : rem;
            drive(1'b1, neg ? -m : m, 1'b0);
            neg = !neg;
            rem -= m;
        end
        drive(1'b0, 0, 1'b1);
    endtask

    task automatic send_avg(input int p);
        for (int w = 0; w < 4; w++) send_window(p);
    endtask

    task automatic do_reset();
        drive(1'b0, 0, 1'b0);
        rst_n = 1'b0;
        repeat (3) drive(1'b0, 0, 1'b0);
        rst_n = 1'b1;
        drive(1'b0, 0, 1'b0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R5 watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        int s0;
        int prev_step;
        string tag;

        // R1: reset state
        repeat (3) drive(1'b0, 0, 1'b0);
        check("R1 reset pwr_est", pwr_est, 0);
        check("R1 reset step_word", step_word, 0);
        check("R1 reset upd_stb", upd_stb, 0);
        rst_n = 1'b1;
        drive(1'b0, 0, 1'b0);
        check("R1 after release step_word", step_word, 0);

        // table walk: R4 estimate, R5 rate, R6/R7/R8/R9 step direction
        prev_step = 0;
        for (int i = 0; i < N_VEC; i++) begin
            s0 = stb_seen;
            for (int w = 0; w < 3; w++) send_window(VEC[i][w]);
            settle();
            check("R5 no strobe before fourth trigger", stb_seen - s0, 0);
            check("R5 estimate held before fourth trigger", pwr_est, (i == 0) ? 0 : VEC[i-1][4]);
            send_window(VEC[i][3]);
            settle();
            check("R5 one strobe per four triggers", stb_seen - s0, 1);
            check("R4 averaged estimate", pwr_est, VEC[i][4]);
            if (i == 0) tag = "R6 first update keeps step";
            else if (VEC[i][5] > prev_step) tag = "R7 step rises";
            else if (VEC[i][5] < prev_step) tag = "R8 step falls";
            else tag = "R9 step holds on equal power";
            check(tag, step_word, VEC[i][5]);
            prev_step = VEC[i][5];
        end

        // R1 again mid-run, then R2 window grouping
        drive(1'b0, 0, 1'b0);
        rst_n = 1'b0;
        drive(1'b0, 0, 1'b0);
        drive(1'b0, 0, 1'b0);
        check("R1 reset mid-run pwr_est", pwr_est, 0);
        check("R1 reset mid-run step_word", step_word, 0);
        rst_n = 1'b1;
        drive(1'b1, 10, 1'b0);
        drive(1'b0, 999, 1'b0);
        drive(1'b1, -20, 1'b1);
        drive(1'b1, 30, 1'b0);
        drive(1'b0, 0, 1'b1);
        send_window(5);
        send_window(5);
        settle();
        check("R2 invalid ignored, trigger-cycle sample in next window", pwr_est, 17);
        check("R6 first update after reset keeps step", step_word, 0);

        // R10 upper limit: strictly rising estimates
        for (int p = 18; p <= 2065; p++) begin
            send_avg(p);
            if (p == 18) begin
                settle();
                check("R7 first rise", step_word, 1);
            end
            if (p == 2064) begin
                settle();
                check("R10 reaches upper limit", step_word, 2047);
            end
        end
        settle();
        check("R10 saturates at upper limit", step_word, 2047);
        check("R4 estimate on ramp", pwr_est, 2065);
        send_avg(4096);
        settle();
        check("R10 holds at upper limit", step_word, 2047);

        // R10 lower limit: strictly falling estimates
        for (int p = 4095; p >= 0; p--) begin
            send_avg(p);
            if (p == 4095) begin
                settle();
                check("R8 first fall", step_word, 2046);
            end
            if (p == 1) begin
                settle();
                check("R10 reaches lower limit", step_word, -2048);
            end
        end
        settle();
        check("R10 saturates at lower limit", step_word, -2048);
        check("R4 estimate at zero", pwr_est, 0);

        // R3 full-scale windows
        do_reset();
        for (int w = 0; w < 4; w++) begin
            repeat (MAX_WIN_LEN) drive(1'b1, -2048, 1'b0);
            drive(1'b0, 0, 1'b1);
        end
        settle();
        check("R3 full-scale window without overflow", pwr_est, 8388608);
        check("R6 step unchanged after full-scale prime", step_word, 0);

        done = 1'b1;
        finish_run();
    end

endmodule